// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block holds one working register and moves its contents by one bit position per clock cycle. Four one-hot control inputs select the operation: shift left, shift right, rotate left or rotate right. A shift takes its new end bit from the `shift_in` input and records the bit that falls off the other end in the `shift_out` flag. A rotate has no separate in and out bits. It passes the word through the `rot_flag` register, which supplies the entering bit and in the same edge takes the leaving bit. In effect the register and that flag form a ring of W+1 bits.

The register is written from `load_data` and read through `rd_data`. The rotate flag has its own write strobe, so software-style sequences can prime it before a rotate. When more than one of the six controls is active in the same cycle, the unit leaves all its state unchanged and raises `err` for one cycle. One bit position is the only shift amount, and sign extension for arithmetic shifts is not supported.

Top module: `shift_rot_unit`

## Requirements
- R1: After reset the register, `shift_out`, `rot_flag` and `err` are all 0.
- R2: With only `load_en` active, the register takes `load_data` at the next edge and both flags keep their values.
- R3: `rd_data` equals the register combinationally while `rd_en` is 1 and is all zeros while it is 0. In a cycle that also updates the register, it shows the value from before the update.
- R4: With only `shl` active, the register becomes {old[W-2:0], shift_in} and `shift_out` becomes the old bit W-1.
- R5: With only `shr` active, the register becomes {shift_in, old[W-1:1]} and `shift_out` becomes the old bit 0.
- R6: With only `rol` active, the register becomes {old[W-2:0], old rot_flag} and `rot_flag` becomes the old bit W-1, both at the same edge.
- R7: With only `ror` active, the register becomes {old rot_flag, old[W-1:1]} and `rot_flag` becomes the old bit 0, both at the same edge.
- R8: A shift leaves `rot_flag` unchanged, and a rotate leaves `shift_out` unchanged.
- R9: With only `rflag_wr` active, `rot_flag` takes `rflag_val` and the register and `shift_out` are unchanged.
- R10: If two or more of {shl, shr, rol, ror, load_en, rflag_wr} are active, nothing changes and `err` is 1 for the following cycle only. In every other case `err` is 0.
- R11: W+1 rotations in one direction restore both the original word and the original `rot_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shl | input | 1 | Shift left by one |
| shr | input | 1 | Shift right by one |
| rol | input | 1 | Rotate left through rot_flag |
| ror | input | 1 | Rotate right through rot_flag |
| load_en | input | 1 | Load register from load_data |
| load_data | input | W | Value to load |
| shift_in | input | 1 | Bit entering on a shift |
| rflag_wr | input | 1 | Write rot_flag |
| rflag_val | input | 1 | Value for rot_flag |
| rd_en | input | 1 | Drive register onto rd_data |
| rd_data | output | W | Register value or zero |
| shift_out | output | 1 | Last bit expelled by a shift |
| rot_flag | output | 1 | Rotate carry-through flag |
| err | output | 1 | One-cycle pulse on control conflict |

## Verification
A read and an update can happen in the same cycle. The bench raises `rd_en` together with a shift or a rotate and samples `rd_data` before the edge, where it must still show the old word. It then samples again after the edge, where the moved word must appear. A second kind of overlap is two operation controls in one cycle, for example a shift with a rotate or a load with a shift. Such a cycle is judged by a steady register and steady flags, an `err` pulse exactly one cycle wide, and a read that returns the unchanged word.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int NCTL = 6;

    // bit positions inside the packed control vector
    localparam int C_SHL  = 0;
    localparam int C_SHR  = 1;
    localparam int C_ROL  = 2;
    localparam int C_ROR  = 3;
    localparam int C_LOAD = 4;
    localparam int C_FSET = 5;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SHL,
        OP_SHR,
        OP_ROL,
        OP_ROR,
        OP_LOAD,
        OP_FSET
    } sru_op_e;

endpackage

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
(
    input  logic [NCTL-1:0] ctl,
    output sru_op_e         op,
    output logic            conflict
);

    localparam int CW = $clog2(NCTL + 1);

    logic [CW-1:0] active_cnt;

    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < NCTL; i++) begin
            active_cnt = active_cnt + CW'(ctl[i]);
        end
    end

    always_comb begin
        conflict = (active_cnt > CW'(1));
        op       = OP_IDLE;
        if (active_cnt == CW'(1)) begin
            if (ctl[C_SHL])       op = OP_SHL;
            else if (ctl[C_SHR])  op = OP_SHR;
            else if (ctl[C_ROL])  op = OP_ROL;
            else if (ctl[C_ROR])  op = OP_ROR;
            else if (ctl[C_LOAD]) op = OP_LOAD;
            else                  op = OP_FSET;
        end
    end

endmodule

// File: rtl/sru_datapath.sv
module sru_datapath
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  sru_op_e       op,
    input  logic [W-1:0]  data_q,
    input  logic          sout_q,
    input  logic          rflag_q,
    input  logic          shift_in,
    input  logic [W-1:0]  load_data,
    input  logic          rflag_val,
    output logic [W-1:0]  data_d,
    output logic          sout_d,
    output logic          rflag_d
);

    logic         fill_bit;
    logic [W-1:0] to_msb;
    logic [W-1:0] to_lsb;

    // rotates draw the entering bit from the flag, shifts from the input
    assign fill_bit = (op == OP_ROL || op == OP_ROR) ? rflag_q : shift_in;

    assign to_msb[0]   = fill_bit;
    assign to_lsb[W-1] = fill_bit;

    for (genvar g = 1; g < W; g++) begin : g_move
        assign to_msb[g]   = data_q[g-1];
        assign to_lsb[g-1] = data_q[g];
    end

    always_comb begin
        data_d  = data_q;
        sout_d  = sout_q;
        rflag_d = rflag_q;
        case (op)
            OP_SHL: begin
                data_d = to_msb;
                sout_d = data_q[W-1];
            end
            OP_SHR: begin
                data_d = to_lsb;
                sout_d = data_q[0];
            end
            OP_ROL: begin
                data_d  = to_msb;
                rflag_d = data_q[W-1];
            end
            OP_ROR: begin
                data_d  = to_lsb;
                rflag_d = data_q[0];
            end
            OP_LOAD: data_d  = load_data;
            OP_FSET: rflag_d = rflag_val;
            default: ;
        endcase
    end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shl,
    input  logic         shr,
    input  logic         rol,
    input  logic         ror,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic         shift_in,
    input  logic         rflag_wr,
    input  logic         rflag_val,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         shift_out,
    output logic         rot_flag,
    output logic         err
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         sout;
        logic         rflag;
        logic         err;
    } sru_state_t;

    sru_state_t      st_d, st_q;
    logic [NCTL-1:0] ctl;
    sru_op_e         op;
    logic            conflict;
    logic [W-1:0]    dp_data;
    logic            dp_sout;
    logic            dp_rflag;
    logic [W-1:0]    data_q;

    always_comb begin
        ctl         = '0;
        ctl[C_SHL]  = shl;
        ctl[C_SHR]  = shr;
        ctl[C_ROL]  = rol;
        ctl[C_ROR]  = ror;
        ctl[C_LOAD] = load_en;
        ctl[C_FSET] = rflag_wr;
    end

    sru_decode u_dec (
        .ctl      (ctl),
        .op       (op),
        .conflict (conflict)
    );

    sru_datapath #(.W(W)) u_dp (
        .op        (op),
        .data_q    (st_q.data),
        .sout_q    (st_q.sout),
        .rflag_q   (st_q.rflag),
        .shift_in  (shift_in),
        .load_data (load_data),
        .rflag_val (rflag_val),
        .data_d    (dp_data),
        .sout_d    (dp_sout),
        .rflag_d   (dp_rflag)
    );

    always_comb begin
        st_d.data  = dp_data;
        st_d.sout  = dp_sout;
        st_d.rflag = dp_rflag;
        st_d.err   = conflict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q    = st_q.data;
    assign rd_data   = rd_en ? data_q : '0;
    assign shift_out = st_q.sout;
    assign rot_flag  = st_q.rflag;
    assign err       = st_q.err;

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shl,
    input logic         shr,
    input logic         rol,
    input logic         ror,
    input logic         load_en,
    input logic [W-1:0] load_data,
    input logic         shift_in,
    input logic         rflag_wr,
    input logic         rflag_val,
    input logic         rd_en,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] data_q,
    input logic         shift_out,
    input logic         rot_flag,
    input logic         err
);

    logic [5:0] c;
    assign c = {rflag_wr, load_en, ror, rol, shr, shl};

    p_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == (rd_en ? data_q : '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b010000) |=> (data_q == $past(load_data))
                             && $stable(shift_out) && $stable(rot_flag));

    p_shl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b000001) |=> (data_q == {$past(data_q[W-2:0]), $past(shift_in)})
                             && (shift_out == $past(data_q[W-1])));

    p_shr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b000010) |=> (data_q == {$past(shift_in), $past(data_q[W-1:1])})
                             && (shift_out == $past(data_q[0])));

    p_rol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b000100) |=> (data_q == {$past(data_q[W-2:0]), $past(rot_flag)})
                             && (rot_flag == $past(data_q[W-1])));

    p_ror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b001000) |=> (data_q == {$past(rot_flag), $past(data_q[W-1:1])})
                             && (rot_flag == $past(data_q[0])));

    p_shift_keeps_rflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b000001 || c == 6'b000010) |=> $stable(rot_flag));

    p_rot_keeps_sout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b000100 || c == 6'b001000) |=> $stable(shift_out));

    p_fset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 6'b100000) |=> (rot_flag == $past(rflag_val))
                             && $stable(data_q) && $stable(shift_out));

    p_conflict_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(c) > 1) |=> $stable(data_q) && $stable(shift_out)
                                && $stable(rot_flag) && err);

    p_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(c) <= 1) |=> !err);

endmodule

bind shift_rot_unit sru_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shl       (shl),
    .shr       (shr),
    .rol       (rol),
    .ror       (ror),
    .load_en   (load_en),
    .load_data (load_data),
    .shift_in  (shift_in),
    .rflag_wr  (rflag_wr),
    .rflag_val (rflag_val),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .data_q    (data_q),
    .shift_out (shift_out),
    .rot_flag  (rot_flag),
    .err       (err)
);

// File: tb/tb_shift_rot_unit.sv
module tb_shift_rot_unit;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shl = 0, shr = 0, rol = 0, ror = 0, load_en = 0;
    logic [W-1:0] load_data = '0;
    logic         shift_in = 0, rflag_wr = 0, rflag_val = 0, rd_en = 0;
    logic [W-1:0] rd_data;
    logic         shift_out, rot_flag, err;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    shift_rot_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .shl(shl), .shr(shr), .rol(rol), .ror(ror),
        .load_en(load_en), .load_data(load_data), .shift_in(shift_in),
        .rflag_wr(rflag_wr), .rflag_val(rflag_val), .rd_en(rd_en),
        .rd_data(rd_data), .shift_out(shift_out), .rot_flag(rot_flag), .err(err)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle of controls at a falling edge, return at the next falling edge
    task automatic step(input logic [5:0] c, input logic [W-1:0] d, input logic si, input logic fv);
        {rflag_wr, load_en, ror, rol, shr, shl} = c;
        load_data = d; shift_in = si; rflag_val = fv;
        @(negedge clk);
        {rflag_wr, load_en, ror, rol, shr, shl} = '0;
    endtask

    task automatic read_word(output logic [W-1:0] v);
        rd_en = 1'b1; #1; v = rd_data; rd_en = 1'b0; #1;
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        read_word(v);
        check("R1 data", v, '0);
        check("R1 shift_out", W'(shift_out), '0);
        check("R1 rot_flag", W'(rot_flag), '0);
        check("R1 err", W'(err), '0);
    endtask

    task automatic t_load_read;
        logic [W-1:0] v;
        step(6'b100000, '0, 0, 1);            // prime rot_flag = 1
        check("R9 rot_flag set", W'(rot_flag), 1);
        step(6'b010000, 8'hA5, 0, 0);
        read_word(v);
        check("R2 load", v, 8'hA5);
        check("R2 rot_flag kept", W'(rot_flag), 1);
        check("R9 data kept across flag write", v, 8'hA5);
        #1;
        check("R3 no read gives zero", rd_data, '0);
    endtask

    task automatic t_shifts;
        logic [W-1:0] v;
        step(6'b000001, '0, 1, 0);            // A5 shl in 1 -> 4B, out 1
        read_word(v);
        check("R4 shl data", v, 8'h4B);
        check("R4 shl out", W'(shift_out), 1);
        check("R8 shl keeps rot_flag", W'(rot_flag), 1);
        step(6'b000010, '0, 1, 0);            // 4B shr in 1 -> A5, out 1
        read_word(v);
        check("R5 shr data", v, 8'hA5);
        check("R5 shr out", W'(shift_out), 1);
        step(6'b000010, '0, 0, 0);            // A5 shr in 0 -> 52, out 1
        step(6'b000001, '0, 0, 0);            // 52 shl in 0 -> A4, out 0
        read_word(v);
        check("R4 shl zero fill", v, 8'hA4);
        check("R4 shl out zero", W'(shift_out), 0);
        check("R8 shifts keep rot_flag", W'(rot_flag), 1);
    endtask

    task automatic t_rotates;
        logic [W-1:0] v;
        step(6'b010000, 8'hA5, 0, 0);
        step(6'b000100, '0, 0, 0);            // A5 rol flag 1 -> 4B, flag 1
        read_word(v);
        check("R6 rol data", v, 8'h4B);
        check("R6 rol flag", W'(rot_flag), 1);
        check("R8 rol keeps shift_out", W'(shift_out), 0);
        step(6'b100000, '0, 0, 0);            // flag 0
        step(6'b001000, '0, 1, 0);            // 4B ror flag 0 -> 25, flag 1
        read_word(v);
        check("R7 ror data ignores shift_in", v, 8'h25);
        check("R7 ror flag", W'(rot_flag), 1);
    endtask

    task automatic t_ring;
        logic [W-1:0] v;
        step(6'b010000, 8'h96, 0, 0);
        step(6'b100000, '0, 0, 1);
        for (int i = 0; i < W + 1; i++) step(6'b000100, '0, 0, 0);
        read_word(v);
        check("R11 rol ring data", v, 8'h96);
        check("R11 rol ring flag", W'(rot_flag), 1);
        for (int i = 0; i < W + 1; i++) step(6'b001000, '0, 0, 0);
        read_word(v);
        check("R11 ror ring data", v, 8'h96);
        check("R11 ror ring flag", W'(rot_flag), 1);
    endtask

    task automatic t_same_cycle_read;
        logic [W-1:0] v;
        step(6'b010000, 8'h3C, 0, 0);
        shl = 1; shift_in = 1; rd_en = 1; #1;
        check("R3 read before update", rd_data, 8'h3C);
        @(negedge clk);
        shl = 0; #1;
        check("R3 read after update", rd_data, 8'h79);
        rd_en = 0;
        check("R4 out bit", W'(shift_out), 0);
    endtask

    task automatic t_conflict;
        logic [W-1:0] v;
        logic         rf;
        rf = rot_flag;
        step(6'b001001, '0, 1, 0);            // shl + ror
        read_word(v);
        check("R10 data held", v, 8'h79);
        check("R10 rot_flag held", W'(rot_flag), W'(rf));
        check("R10 err pulse", W'(err), 1);
        step(6'b000000, '0, 0, 0);
        check("R10 err one cycle", W'(err), 0);
        step(6'b010010, 8'hFF, 1, 0);         // load + shr
        read_word(v);
        check("R10 load blocked", v, 8'h79);
        check("R10 shift_out held", W'(shift_out), 0);
        check("R10 err again", W'(err), 1);
        step(6'b100100, '0, 0, ~rf);          // flag write + rol
        check("R10 flag write blocked", W'(rot_flag), W'(rf));
        step(6'b000001, '0, 0, 0);
        check("R10 single op no err", W'(err), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_shifts();
        t_rotates();
        t_ring();
        t_same_cycle_read();
        t_conflict();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule